// File: doc/BRIEF.md
# Single-Bit Sector ECC Checker

This block turns the 32-bit parity word that a flash controller gathers over one 512-byte sector into a 3-byte check code, and on read-back decides what that code says about the sector. The raw parity word has two 4-bit reserved gaps. The block drops these gaps, packs the 24 meaningful bits and inverts them. An erased page, where both the stored bytes and the fresh code are all ones, therefore compares clean.

For a check, the caller presents the stored code and the freshly gathered parity. The block XORs the stored code with the freshly packed code and sorts the result into one of four classes: no error, one correctable data bit, a single flipped bit in the stored code itself, or uncorrectable. For a correctable data bit it returns the byte index and a one-hot bit mask. The caller XORs that mask into the byte at that index in its own sector buffer.

A one-cycle `start` strobe launches either a pack or a check. One clock later `done` pulses and the registered results appear. The results hold until the next start. The running parity generator and the sector buffer belong to the surrounding logic.

Top module: `secc_sector_checker`

## Requirements
- R1: Packing keeps raw bits 11:0 as code bits 11:0 and moves raw bits 27:16 down to code bits 23:12, then inverts all 24 bits. Raw bits 31:28 and 15:12 have no effect on any output. Code byte k is `codeOut[8k+7:8k]`, and byte 0 is the first byte stored.
- R2: A stored code of 0xFFFFFF checked against raw parity whose kept bits are all zero reports status 0 (no error).
- R3: The difference is the stored code XOR the freshly packed code. A zero difference gives status 0, with `errByte` 0 and `errMask` 0.
- R4: When the upper 12 bits of the difference XOR its lower 12 bits equal 0xFFF, and the index in difference bits 23:15 is below the sector size, the status is 1 (corrected). `errByte` is then difference bits 23:15, and `errMask` has only bit number difference[14:12] set.
- R5: A difference that passes the R4 halves test but has an index of at least the sector size (parameter `SECTOR_BYTES`) reports status 3, with `errByte` 0 and `errMask` 0.
- R6: A difference with exactly one bit set reports status 2 (fault in the code only), with `errByte` 0 and `errMask` 0, so no data bit is touched.
- R7: Every other nonzero difference reports status 3 (uncorrectable), with `errByte` 0 and `errMask` 0.
- R8: `done` is high in exactly the cycle after each cycle in which `start` is high. Results load at that same edge. While `start` is low, every result output holds its value whatever the data inputs do. Back-to-back starts give back-to-back results.
- R9: After reset, `done`, `status`, `codeOut`, `errByte` and `errMask` are all zero.
- R10: A pack operation (`opCheck` low) returns the packed code on `codeOut`, with status 0 and `errByte` and `errMask` 0. A check operation also returns the freshly packed code on `codeOut`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch one operation this cycle |
| opCheck | input | 1 | 1 selects check, 0 selects pack |
| rawParity | input | 32 | Raw parity word with reserved nibbles |
| storedCode | input | 24 | Code read back from the spare area, byte 0 in bits 7:0 |
| done | output | 1 | Result valid pulse, one cycle after start |
| status | output | 2 | 0 none, 1 corrected, 2 code-only, 3 uncorrectable |
| codeOut | output | 24 | Freshly packed, inverted code |
| errByte | output | 9 | Byte index of the bit to flip |
| errMask | output | 8 | One-hot mask of the bit to flip |

## Verification
The hardest case to reach is an index at or beyond the sector size. With 9 index bits and 512-byte sectors it cannot occur at the default parameters. The bench therefore runs a second instance configured for 256-byte sectors on the same inputs, so an index of 256 or more is corrected by one instance and refused by the other. Correctable differences almost never arise from random stimulus. The bench builds them on purpose: it chooses a byte and bit, forms the complementary-halves difference from them, and derives the raw parity that yields that difference against a random stored code. Random reserved nibbles are mixed in throughout.

// File: rtl/secc_pkg.sv
package secc_pkg;

  typedef enum logic [1:0] {
    ST_NONE      = 2'd0,
    ST_FIXED     = 2'd1,
    ST_CODE_ONLY = 2'd2,
    ST_UNCORR    = 2'd3
  } eccStatusT;

  typedef struct packed {
    logic loadPack;
    logic loadCheck;
  } ctlStrobeT;

endpackage

// File: rtl/secc_ctrl.sv
module secc_ctrl
  import secc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      opCheck,
  output ctlStrobeT strobe,
  output logic      done
);

  always_comb begin
    strobe.loadPack  = start & ~opCheck;
    strobe.loadCheck = start & opCheck;
  end

  always_ff @(posedge clk) begin
    if (!rstN) done <= 1'b0;
    else       done <= start;
  end

  // R8
  done_follows_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(start));

  // R8
  start_gives_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    start |=> done);

  // R10
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loadPack, strobe.loadCheck}));

endmodule

// File: rtl/secc_datapath.sv
module secc_datapath
  import secc_pkg::*;
#(
  parameter int HALF_W       = 12,
  parameter int RSV_W        = 4,
  parameter int SECTOR_BYTES = 512,
  localparam int CODE_W      = 2 * HALF_W,
  localparam int RAW_W       = 2 * (HALF_W + RSV_W),
  localparam int BIT_SEL_W   = 3,
  localparam int BYTE_IDX_W  = HALF_W - BIT_SEL_W,
  localparam int MASK_W      = 1 << BIT_SEL_W
)(
  input  logic                  clk,
  input  logic                  rstN,
  input  ctlStrobeT             strobe,
  input  logic [RAW_W-1:0]      rawParity,
  input  logic [CODE_W-1:0]     storedCode,
  output logic [CODE_W-1:0]     codeOut,
  output eccStatusT             status,
  output logic [BYTE_IDX_W-1:0] errByte,
  output logic [MASK_W-1:0]     errMask
);

  localparam int SEG_W = HALF_W + RSV_W;
  localparam logic [BYTE_IDX_W:0] SECTOR_LIM = SECTOR_BYTES[BYTE_IDX_W:0];

  logic [CODE_W-1:0]     packedBits;
  logic [CODE_W-1:0]     freshCode;
  logic [CODE_W-1:0]     diffWord;
  logic [HALF_W-1:0]     halfXor;
  logic                  halvesComp;
  logic                  singleBit;
  logic [BYTE_IDX_W-1:0] diffByte;
  logic [BIT_SEL_W-1:0]  diffBit;
  logic                  idxInRange;
  eccStatusT             nextStatus;
  logic [BYTE_IDX_W-1:0] nextByte;
  logic [MASK_W-1:0]     nextMask;

  // squeeze each segment's reserved nibble out of the raw word
  for (genvar h = 0; h < 2; h++) begin : g_seg
    assign packedBits[h*HALF_W +: HALF_W] = rawParity[h*SEG_W +: HALF_W];
  end

  assign freshCode = ~packedBits;
  assign diffWord  = storedCode ^ freshCode;
  assign halfXor   = diffWord[CODE_W-1:HALF_W] ^ diffWord[HALF_W-1:0];
  assign halvesComp = &halfXor;
  assign singleBit  = (diffWord != '0) && ((diffWord & (diffWord - 1'b1)) == '0);
  assign diffByte   = diffWord[CODE_W-1 -: BYTE_IDX_W];
  assign diffBit    = diffWord[HALF_W +: BIT_SEL_W];

  if (SECTOR_BYTES >= (1 << BYTE_IDX_W)) begin : g_full_range
    assign idxInRange = 1'b1;
  end else begin : g_limited_range
    assign idxInRange = ({1'b0, diffByte} < SECTOR_LIM);
  end

  always_comb begin
    nextStatus = ST_NONE;
    nextByte   = '0;
    nextMask   = '0;
    if (diffWord == '0) begin
      nextStatus = ST_NONE;
    end else if (halvesComp) begin
      if (idxInRange) begin
        nextStatus = ST_FIXED;
        nextByte   = diffByte;
        nextMask   = MASK_W'(1) << diffBit;
      end else begin
        nextStatus = ST_UNCORR;
      end
    end else if (singleBit) begin
      nextStatus = ST_CODE_ONLY;
    end else begin
      nextStatus = ST_UNCORR;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      codeOut <= '0;
      status  <= ST_NONE;
      errByte <= '0;
      errMask <= '0;
    end else if (strobe.loadCheck) begin
      codeOut <= freshCode;
      status  <= nextStatus;
      errByte <= nextByte;
      errMask <= nextMask;
    end else if (strobe.loadPack) begin
      codeOut <= freshCode;
      status  <= ST_NONE;
      errByte <= '0;
      errMask <= '0;
    end
  end

  // R4
  fix_mask_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (status == ST_FIXED) |-> ($onehot(errMask) && ({1'b0, errByte} < SECTOR_LIM)));

  // R6
  code_only_untouched_chk: assert property (@(posedge clk) disable iff (!rstN)
    (status == ST_CODE_ONLY) |-> (errMask == '0 && errByte == '0));

  // R3
  clean_no_pointer_chk: assert property (@(posedge clk) disable iff (!rstN)
    (status == ST_NONE) |-> (errMask == '0 && errByte == '0));

  // R8
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.loadPack || strobe.loadCheck) |=>
      ($stable(codeOut) && $stable(status) && $stable(errByte) && $stable(errMask)));

endmodule

// File: rtl/secc_sector_checker.sv
module secc_sector_checker
  import secc_pkg::*;
#(
  parameter int HALF_W       = 12,
  parameter int RSV_W        = 4,
  parameter int SECTOR_BYTES = 512,
  localparam int CODE_W      = 2 * HALF_W,
  localparam int RAW_W       = 2 * (HALF_W + RSV_W),
  localparam int BYTE_IDX_W  = HALF_W - 3,
  localparam int MASK_W      = 8
)(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic                  opCheck,
  input  logic [RAW_W-1:0]      rawParity,
  input  logic [CODE_W-1:0]     storedCode,
  output logic                  done,
  output logic [1:0]            status,
  output logic [CODE_W-1:0]     codeOut,
  output logic [BYTE_IDX_W-1:0] errByte,
  output logic [MASK_W-1:0]     errMask
);

  ctlStrobeT strobe;
  eccStatusT statusQ;

  secc_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .opCheck (opCheck),
    .strobe  (strobe),
    .done    (done)
  );

  secc_datapath #(
    .HALF_W       (HALF_W),
    .RSV_W        (RSV_W),
    .SECTOR_BYTES (SECTOR_BYTES)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .rawParity  (rawParity),
    .storedCode (storedCode),
    .codeOut    (codeOut),
    .status     (statusQ),
    .errByte    (errByte),
    .errMask    (errMask)
  );

  assign status = statusQ;

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |=> (!done && status == 2'd0 && codeOut == '0));

endmodule

// File: tb/secc_sector_checker_bench.sv
module secc_sector_checker_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        opCheck = 1'b0;
  logic [31:0] rawParity = '0;
  logic [23:0] storedCode = '0;

  logic        doneA, doneB;
  logic [1:0]  statusA, statusB;
  logic [23:0] codeA, codeB;
  logic [8:0]  byteA, byteB;
  logic [7:0]  maskA, maskB;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  secc_sector_checker u_secc_sector_checker (
    .clk(clk), .rstN(rstN), .start(start), .opCheck(opCheck),
    .rawParity(rawParity), .storedCode(storedCode),
    .done(doneA), .status(statusA), .codeOut(codeA),
    .errByte(byteA), .errMask(maskA)
  );

  secc_sector_checker #(.SECTOR_BYTES(256)) u_secc_sector_checker_small (
    .clk(clk), .rstN(rstN), .start(start), .opCheck(opCheck),
    .rawParity(rawParity), .storedCode(storedCode),
    .done(doneB), .status(statusB), .codeOut(codeB),
    .errByte(byteB), .errMask(maskB)
  );

  task automatic check(input string req, input logic ok,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] packRef(input logic [31:0] r);
    return ~{r[27:16], r[11:0]};
  endfunction

  function automatic logic [31:0] mkRaw(input logic [23:0] code,
                                        input logic [3:0] hiRsv,
                                        input logic [3:0] loRsv);
    logic [23:0] p;
    p = ~code;
    return {hiRsv, p[23:12], loRsv, p[11:0]};
  endfunction

  // complementary-halves difference for a chosen byte and bit
  function automatic logic [23:0] fixDiff(input logic [8:0] b, input logic [2:0] k);
    logic [11:0] up;
    up = {b, k};
    return {up, ~up};
  endfunction

  task automatic classify(input logic [23:0] d, input int sector,
                          output logic [1:0] st, output logic [8:0] by,
                          output logic [7:0] mk);
    st = 2'd0; by = '0; mk = '0;
    if (d == 0) st = 2'd0;
    else if ((d[23:12] ^ d[11:0]) == 12'hFFF) begin
      if (int'(d[23:15]) < sector) begin
        st = 2'd1; by = d[23:15]; mk = 8'd1 << d[14:12];
      end else st = 2'd3;
    end else if ($countones(d) == 1) st = 2'd2;
    else st = 2'd3;
  endtask

  task automatic runOp(input logic chk, input logic [31:0] raw,
                       input logic [23:0] stored, input string req);
    logic [1:0] stA, stB;
    logic [8:0] byA, byB;
    logic [7:0] mkA, mkB;
    logic [23:0] code;
    code = packRef(raw);
    if (chk) begin
      classify(stored ^ code, 512, stA, byA, mkA);
      classify(stored ^ code, 256, stB, byB, mkB);
    end else begin
      stA = 0; byA = 0; mkA = 0; stB = 0; byB = 0; mkB = 0;
    end
    @(negedge clk);
    opCheck = chk; rawParity = raw; storedCode = stored; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({req, " R8 done"}, doneA && doneB, {doneA, doneB}, 2'b11);
    check({req, " R1 code"}, codeA == code && codeB == code, codeA, code);
    check({req, " status"}, statusA == stA, statusA, stA);
    check({req, " byte"}, byteA == byA, byteA, byA);
    check({req, " mask"}, maskA == mkA, maskA, mkA);
    check({req, " small status"}, statusB == stB && byteB == byB && maskB == mkB,
          {statusB, byteB, maskB}, {stB, byB, mkB});
    // R8: data inputs change while idle, outputs must hold
    rawParity = $urandom; storedCode = 24'($urandom); opCheck = ~chk;
    @(negedge clk);
    check({req, " R8 hold"}, !doneA && codeA == code && statusA == stA &&
          byteA == byA && maskA == mkA, {doneA, statusA, byteA, maskA, codeA},
          {1'b0, stA, byA, mkA, code});
  endtask

  initial begin
    while (!finished) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !finished) begin
        fails++; checks++;
        $display("FAIL R8 watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [23:0] st;
    logic [31:0] raw;
    void'($urandom(32'h5ECC_0011));
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 reset", !doneA && statusA == 0 && codeA == 0 && byteA == 0 && maskA == 0,
          {doneA, statusA, byteA, maskA, codeA}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 / R10 pack with known value; byte 0 first
    runOp(1'b0, 32'h1234_5678, 24'h0, "R10 pack");
    check("R1 byte0", codeA[7:0] == 8'h87, codeA[7:0], 8'h87);
    check("R1 byte2", codeA[23:16] == 8'hDC, codeA[23:16], 8'hDC);
    // R1 reserved nibbles ignored
    runOp(1'b0, 32'hE234_A678, 24'h0, "R1 reserved");
    check("R1 reserved same code", codeA == 24'hDCB987, codeA, 24'hDCB987);

    // R2 erased page
    runOp(1'b1, 32'h0000_0000, 24'hFFFFFF, "R2 erased");
    check("R2 erased clean", statusA == 0, statusA, 0);
    runOp(1'b1, 32'hF000_F000, 24'hFFFFFF, "R2 erased rsv");

    // R3 clean arbitrary
    st = 24'h3C5A96;
    runOp(1'b1, mkRaw(st, 4'h5, 4'hA), st, "R3 clean");

    // R6 single bit in code
    runOp(1'b1, 32'h0, 24'hFFFFFF ^ 24'h000020, "R6 low code bit");
    runOp(1'b1, 32'h0, 24'hFFFFFF ^ 24'h800000, "R6 top code bit");

    // R4 correctable, including index limits
    st = 24'h13579B;
    runOp(1'b1, mkRaw(st ^ fixDiff(9'd0, 3'd0), 4'h0, 4'hF), st, "R4 byte0 bit0");
    runOp(1'b1, mkRaw(st ^ fixDiff(9'd511, 3'd7), 4'h3, 4'h3), st, "R4 byte511 bit7");
    runOp(1'b1, mkRaw(st ^ fixDiff(9'd255, 3'd2), 4'h0, 4'h0), st, "R4 byte255");
    check("R4 byte255 small fixed", statusB == 2'd1 && byteB == 9'd255, {statusB, byteB}, {2'd1, 9'd255});
    // R5 index beyond the small sector
    runOp(1'b1, mkRaw(st ^ fixDiff(9'd256, 3'd4), 4'h0, 4'h0), st, "R5 byte256");
    check("R5 small refuses", statusB == 2'd3 && maskB == 0, {statusB, maskB}, {2'd3, 8'd0});
    check("R4 large fixes", statusA == 2'd1 && maskA == 8'h10, {statusA, maskA}, {2'd1, 8'h10});

    // R7 multi-bit
    runOp(1'b1, mkRaw(st ^ 24'h000003, 4'h0, 4'h0), st, "R7 two bits");
    check("R7 two bits uncorr", statusA == 2'd3, statusA, 2'd3);
    runOp(1'b1, mkRaw(st ^ 24'h800001, 4'h0, 4'h0), st, "R7 far bits");

    // R8 back-to-back starts
    @(negedge clk);
    opCheck = 1'b0; rawParity = 32'h0000_0000; start = 1'b1;
    @(negedge clk);
    check("R8 b2b first", doneA && codeA == 24'hFFFFFF, codeA, 24'hFFFFFF);
    rawParity = 32'h0FFF_0FFF;
    @(negedge clk);
    start = 1'b0;
    check("R8 b2b second", doneA && codeA == 24'h000000, {doneA, codeA}, {1'b1, 24'h0});
    @(negedge clk);
    check("R8 b2b ends", !doneA, doneA, 0);

    // random mix
    for (int i = 0; i < 300; i++) begin
      logic [23:0] d;
      int kind;
      st = 24'($urandom);
      kind = int'($urandom % 5);
      case (kind)
        0: d = 24'h0;
        1: d = fixDiff(9'($urandom), 3'($urandom));
        2: d = 24'h1 << ($urandom % 24);
        default: d = 24'($urandom);
      endcase
      raw = mkRaw(st ^ d, 4'($urandom), 4'($urandom));
      runOp(($urandom % 8) != 0, raw, st, "R4 R5 R6 R7 R10 random");
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule